// File: doc/BRIEF.md
# Single-Word Interrupt Controller Register

This block gathers up to fifteen interrupt sources into one 32-bit status/control word and drives a single interrupt request line toward a processor. Each source, whether it is a held level or a one-cycle pulse, sets a sticky pending flag. Software clears a pending flag by writing a 1 to its position. The same word also holds one enable bit per source and a master enable bit at the top.

Enable bits follow a write-1-to-affect rule as well. On a write, the value of the top bit decides what the 1s in the enable field do. If the top bit is 1, they turn the matching enables on. If the top bit is 0, they turn the matching enables off. Every write, including one made only to acknowledge, also copies the top bit into the master enable. Software that acknowledges must therefore write the master enable value it wants to keep.

The request line is high when the master enable is on and at least one pending flag has its enable bit set. A read returns the whole word, with a summary bit that reports whether any flag is pending.

Top module: `irq_split_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0 and `irq_o` is 0. All flags, enables and the master enable are cleared.
- R2: A source that is high at a clock edge sets its pending flag, bit i of `rd_data` for source i. The flag stays set after the source goes low.
- R3: A write clears each pending flag whose bit in `wr_data[NSRC-1:0]` is 1. Flags whose bit is 0 keep their value.
- R4: If a source is high in the same cycle as a write that acknowledges its flag, the flag stays set.
- R5: A write with `wr_data[31]` = 1 sets each enable bit `rd_data[16+i]` for which `wr_data[16+i]` is 1. The other enable bits keep their value.
- R6: A write with `wr_data[31]` = 0 clears each enable bit `rd_data[16+i]` for which `wr_data[16+i]` is 1. The other enable bits keep their value.
- R7: Every write, including a pure acknowledge, loads `wr_data[31]` into the master enable, which reads back as `rd_data[31]`.
- R8: `irq_o` is 1 exactly when the master enable is 1 and some pending flag has its enable bit set. With the default `IRQ_REG` = 0, it follows the state with no added delay.
- R9: `rd_data[15]` is 1 whenever any pending flag is set, whatever the enables are.
- R10: The readback layout is: bit 31 master enable, bits [16+NSRC-1:16] enables, bit 15 summary, bits [NSRC-1:0] pending flags. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt sources, active high |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data word |
| rd_data | output | 32 | Status word readback |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Flags, enables and the master enable are all registered. A source pulse or a write therefore shows up in `rd_data` one clock edge after the cycle in which it was presented. With the default build, `irq_o` is combinational from that state and changes on the same edge. The bench drives inputs on the falling edge and holds them for one full cycle. It samples on the next falling edge, which is the first point where the new state and request can be seen. The same-cycle cases for R4 are made by presenting a source pulse and an acknowledge write in one cycle.

// File: rtl/irq_split_pkg.sv
package irq_split_pkg;
   localparam int WORD_W  = 32;
   localparam int HALF_W  = WORD_W / 2;
   localparam int GIE_BIT = WORD_W - 1;
   localparam int SUM_BIT = HALF_W - 1;
   localparam int EN_LSB  = HALF_W;
   localparam int MAX_SRC = HALF_W - 1;

   typedef enum logic {
      MASK_CLEAR = 1'b0,
      MASK_SET   = 1'b1
   } mask_op_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int N = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   for (genvar g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_o[g] <= 1'b0;
         else if (set_i[g])
            flag_o[g] <= 1'b1;
         else if (clr_i[g])
            flag_o[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
   import irq_split_pkg::*;
#(
   parameter int N = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  mask_op_e     op_i,
   input  logic [N-1:0] sel_i,
   output logic [N-1:0] en_o,
   output logic         gie_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o  <= '0;
         gie_o <= 1'b0;
      end else if (wr_i) begin
         gie_o <= (op_i == MASK_SET);
         if (op_i == MASK_SET)
            en_o <= en_o | sel_i;
         else
            en_o <= en_o & ~sel_i;
      end
   end
endmodule

// File: rtl/irq_split_ctrl.sv
module irq_split_ctrl
   import irq_split_pkg::*;
#(
   parameter int NSRC    = 15,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_i,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_data,
   output logic              irq_o
);
   if (NSRC < 1 || NSRC > MAX_SRC) begin : g_bad_nsrc
      $error("NSRC must lie in 1..%0d", MAX_SRC);
   end

   logic [NSRC-1:0] flags;
   logic [NSRC-1:0] enables;
   logic            gie;
   logic [NSRC-1:0] ack_vec;
   mask_op_e        op;
   logic            req_now;
   logic            unused_wbits;

   assign ack_vec = wr_en ? wr_data[NSRC-1:0] : '0;
   assign op      = wr_data[GIE_BIT] ? MASK_SET : MASK_CLEAR;
   assign unused_wbits = &{1'b0, wr_data};

   irq_flag_bank #(.N(NSRC)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (src_i),
      .clr_i  (ack_vec),
      .flag_o (flags)
   );

   irq_mask_reg #(.N(NSRC)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (wr_en),
      .op_i  (op),
      .sel_i (wr_data[EN_LSB +: NSRC]),
      .en_o  (enables),
      .gie_o (gie)
   );

   assign req_now = gie & (|(flags & enables));

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= req_now;
      end
   end else begin : g_irq_comb
      assign irq_o = req_now;
   end

   always_comb begin
      rd_data                  = '0;
      rd_data[GIE_BIT]         = gie;
      rd_data[EN_LSB +: NSRC]  = enables;
      rd_data[SUM_BIT]         = |flags;
      rd_data[NSRC-1:0]        = flags;
   end
endmodule

// File: rtl/irq_split_ctrl_chk.sv
module irq_split_ctrl_chk
   import irq_split_pkg::*;
#(
   parameter int NSRC    = 15,
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NSRC-1:0]   src_i,
   input logic              wr_en,
   input logic [WORD_W-1:0] wr_data,
   input logic [WORD_W-1:0] rd_data,
   input logic              irq_o
);
   logic [NSRC-1:0] fl, en;
   logic            req;
   assign fl  = rd_data[NSRC-1:0];
   assign en  = rd_data[EN_LSB +: NSRC];
   assign req = rd_data[GIE_BIT] & (|(fl & en));

   a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_i) |=> ((fl & $past(src_i)) == $past(src_i)));

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> (fl == ($past(fl) | $past(src_i))));

   a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (fl == (($past(fl) & ~$past(wr_data[NSRC-1:0])) | $past(src_i))));

   a_r5_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[GIE_BIT]) |=> (en == ($past(en) | $past(wr_data[EN_LSB +: NSRC]))));

   a_r6_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[GIE_BIT]) |=> (en == ($past(en) & ~$past(wr_data[EN_LSB +: NSRC]))));

   a_r7_gie: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[GIE_BIT] == $past(wr_data[GIE_BIT])));

   a_r9_summary: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[SUM_BIT] == (|fl));

   if (IRQ_REG) begin : g_chk_ff
      a_r8_irq: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq_o == $past(req)));
   end else begin : g_chk_comb
      a_r8_irq: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o == req);
   end
endmodule

bind irq_split_ctrl irq_split_ctrl_chk #(.NSRC(NSRC), .IRQ_REG(IRQ_REG)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .src_i   (src_i),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .irq_o   (irq_o)
);

// File: tb/tb_irq_split_ctrl.sv
`timescale 1ns/1ps
module tb_irq_split_ctrl;
   localparam int NSRC = 15;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_i = '0;
   logic            wr_en = 1'b0;
   logic [31:0]     wr_data = '0;
   logic [31:0]     rd_data;
   logic            irq_o;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   irq_split_ctrl #(.NSRC(NSRC)) dut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic state(input string req, input logic [31:0] rd_exp, input logic irq_exp);
      check(req, rd_data, rd_exp);
      check(req, {31'd0, irq_o}, {31'd0, irq_exp});
   endtask

   task automatic cyc(input logic [NSRC-1:0] s, input logic w, input logic [31:0] d);
      @(negedge clk);
      src_i = s; wr_en = w; wr_data = d;
      @(negedge clk);
      src_i = '0; wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic t_reset;
      state("R1", 32'h0000_0000, 1'b0);
   endtask

   task automatic t_latch;
      cyc(15'h0008, 1'b0, 32'h0);
      state("R2/R9", 32'h0000_8008, 1'b0);
      @(negedge clk);
      state("R2 sticky", 32'h0000_8008, 1'b0);
   endtask

   task automatic t_enable;
      cyc('0, 1'b1, 32'h8008_0000);
      state("R5/R8/R10", 32'h8008_8008, 1'b1);
   endtask

   task automatic t_ack;
      cyc('0, 1'b1, 32'h8000_0008);
      state("R3 clear", 32'h8008_0000, 1'b0);
      cyc(15'h0021, 1'b0, 32'h0);
      state("R2 two", 32'h8008_8021, 1'b0);
      cyc('0, 1'b1, 32'h8000_0001);
      state("R3 zero keeps", 32'h8008_8020, 1'b0);
   endtask

   task automatic t_disable;
      cyc('0, 1'b1, 32'h0008_0000);
      state("R6", 32'h0000_8020, 1'b0);
      cyc('0, 1'b1, 32'h8020_0000);
      state("R5 R8", 32'h8020_8020, 1'b1);
      cyc('0, 1'b1, 32'h0000_0000);
      state("R7 gie off", 32'h0020_8020, 1'b0);
      cyc('0, 1'b1, 32'h8000_0000);
      state("R7 gie on", 32'h8020_8020, 1'b1);
   endtask

   task automatic t_priority;
      cyc(15'h0020, 1'b1, 32'h8000_0020);
      state("R4", 32'h8020_8020, 1'b1);
      cyc('0, 1'b1, 32'h8000_0020);
      state("R3 after R4", 32'h8020_0000, 1'b0);
   endtask

   task automatic t_top_and_level;
      cyc('0, 1'b1, 32'hC000_0000);
      state("R5 top", 32'hC020_0000, 1'b0);
      cyc(15'h4000, 1'b0, 32'h0);
      state("R10 top", 32'hC020_C000, 1'b1);
      cyc('0, 1'b1, 32'hC000_4000);
      state("R3 top", 32'hC020_0000, 1'b0);
      @(negedge clk);
      src_i = 15'h0080;
      @(negedge clk);
      wr_en = 1'b1; wr_data = 32'h8000_0080;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      state("R4 level", 32'hC020_8080, 1'b0);
      src_i = '0;
      cyc('0, 1'b1, 32'h8000_0080);
      state("R3 level", 32'hC020_0000, 1'b0);
   endtask

   initial begin
      #10000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_latch;
      t_enable;
      t_ack;
      t_disable;
      t_priority;
      t_top_and_level;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule